// File: doc/BRIEF.md
# Floating-Point Status Register Unit

This unit holds the floating-point accrued exception flags (5 bits) and the dynamic rounding mode (3 bits). Software sees this state through three register views. The flags view shows the flags alone. The rounding view shows the rounding mode alone. The combined view shows both fields. When the core reports that the vector extension is present, the combined view also carries the vector fixed-point rounding mode (2 bits) and the vector saturation flag (1 bit). Those two fields are stored in this unit.

The core's CSR stage sends one request per cycle: a valid strobe, a 12-bit register number, a write flag and write data that is already merged. The unit answers in the same cycle with the old value of the register, an illegal-access flag and a dirty pulse. The dirty pulse tells the status logic to set the floating-point state field to its dirty encoding. The unit accepts every request and never applies back-pressure, so there is no ready signal. The request strobe alone qualifies the request fields. Floating-point arithmetic and the flag updates that come from execution are handled elsewhere.

Top module: `fpcsr_unit`

## Requirements
- R1: After reset the flags, rounding mode, vector rounding mode and vector saturation flag are all zero.
- R2: A write to the flags view (register 0x001) stores write-data bits [4:0] and discards all other bits. A read of this view returns the flags in bits [4:0], with all higher bits zero.
- R3: A write to the rounding view (register 0x002) stores write-data bits [2:0] and discards all other bits. A read of this view returns the rounding mode in bits [2:0], with all higher bits zero.
- R4: The combined view (register 0x003) places the flags at bits [4:0] and the rounding mode at bits [7:5]. A write to it updates both fields from those positions. Bits [31:11] always read as zero.
- R5: When vector-present is high, the combined view also reads and writes the vector saturation flag at bit 8 and the vector rounding mode at bits [10:9].
- R6: When vector-present is low, combined-view bits [10:8] read as zero, and a write leaves the stored vector fields unchanged.
- R7: When FP-enable is low and debugger access is low, any access to the flags or rounding view raises the illegal flag. The same holds for the combined view when vector-present is also low. An illegal access returns read data of zero, changes no state and gives no dirty pulse.
- R8: When debugger access is high, the permission check passes whatever the value of FP-enable.
- R9: When vector-present is high, the combined view is accessible even with FP-enable low. The flags and rounding views are still refused in that case.
- R10: The dirty pulse is high in exactly those cycles that carry a valid, legal write to one of the three views. Reads and idle cycles never raise it.
- R11: A write through any view is visible through the other two views from the next cycle onward.
- R12: A request to any other register number is not answered. The illegal flag stays low, the read data is zero, no state changes and no dirty pulse is raised.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | A register request is present this cycle |
| req_addr | input | 12 | Register number |
| req_we | input | 1 | Request writes the register |
| req_wdata | input | 32 | Merged write data |
| fp_enable | input | 1 | Floating-point unit is enabled |
| vec_present | input | 1 | Vector extension is present |
| dbg_access | input | 1 | Request comes from the debugger |
| rsp_rdata | output | 32 | Old value of the addressed view; zero when illegal or unanswered |
| rsp_illegal | output | 1 | Access refused by the permission check |
| fs_dirty | output | 1 | Pulse: set the floating-point state field to dirty |

## Verification
Read data, the illegal flag and the dirty pulse are combinational responses, valid in the same cycle as the request. Each reflects the state as it stood before that cycle's clock edge. A write takes effect at the next rising edge, so its result first appears through a read one cycle later. The bench applies each request at a falling edge and samples all three responses a quarter period later. Each row of its table therefore checks the responses to its own request, together with the state left by the row before it.

// File: rtl/fpcsr_pkg.sv
package fpcsr_pkg;
  typedef enum logic [1:0] {
    VIEW_NONE  = 2'd0,
    VIEW_FLAGS = 2'd1,
    VIEW_RMODE = 2'd2,
    VIEW_FULL  = 2'd3
  } view_e;
endpackage

// File: rtl/fpcsr_decode.sv
module fpcsr_decode
  import fpcsr_pkg::*;
#(
  parameter int ADDR_W = 12,
  parameter logic [ADDR_W-1:0] ADDR_FLAGS = 12'h001,
  parameter logic [ADDR_W-1:0] ADDR_RMODE = 12'h002,
  parameter logic [ADDR_W-1:0] ADDR_FULL  = 12'h003
) (
  input  logic              req_valid,
  input  logic [ADDR_W-1:0] req_addr,
  output view_e             view
);
  always_comb begin
    view = VIEW_NONE;
    if (req_valid) begin
      if (req_addr == ADDR_FLAGS)      view = VIEW_FLAGS;
      else if (req_addr == ADDR_RMODE) view = VIEW_RMODE;
      else if (req_addr == ADDR_FULL)  view = VIEW_FULL;
    end
  end
endmodule

// File: rtl/fpcsr_guard.sv
module fpcsr_guard
  import fpcsr_pkg::*;
(
  input  view_e view,
  input  logic  fp_enable,
  input  logic  vec_present,
  input  logic  dbg_access,
  output logic  hit,
  output logic  illegal
);
  logic full_bypass;

  always_comb begin
    hit         = (view != VIEW_NONE);
    // combined view stays reachable for vector code when FP is off
    full_bypass = (view == VIEW_FULL) && vec_present;
    illegal     = hit && !dbg_access && !fp_enable && !full_bypass;
  end
endmodule

// File: rtl/fpcsr_state.sv
module fpcsr_state
  import fpcsr_pkg::*;
#(
  parameter int FLAG_W = 5,
  parameter int RM_W   = 3,
  parameter int VXRM_W = 2,
  localparam int RM_LSB    = FLAG_W,
  localparam int VXSAT_POS = FLAG_W + RM_W,
  localparam int VXRM_LSB  = VXSAT_POS + 1,
  localparam int FULL_W    = VXRM_LSB + VXRM_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  view_e             view,
  input  logic              vec_present,
  input  logic [FULL_W-1:0] wdata,
  output logic [FLAG_W-1:0] flags_q,
  output logic [RM_W-1:0]   rm_q,
  output logic              vxsat_q,
  output logic [VXRM_W-1:0] vxrm_q
);
  logic [FLAG_W-1:0] flags_d;
  logic [RM_W-1:0]   rm_d;
  logic              vxsat_d;
  logic [VXRM_W-1:0] vxrm_d;

  always_comb begin
    flags_d = flags_q;
    rm_d    = rm_q;
    vxsat_d = vxsat_q;
    vxrm_d  = vxrm_q;
    if (wr_en) begin
      unique case (view)
        VIEW_FLAGS: flags_d = wdata[FLAG_W-1:0];
        VIEW_RMODE: rm_d    = wdata[RM_W-1:0];
        VIEW_FULL: begin
          flags_d = wdata[FLAG_W-1:0];
          rm_d    = wdata[RM_LSB +: RM_W];
          if (vec_present) begin
            vxsat_d = wdata[VXSAT_POS];
            vxrm_d  = wdata[VXRM_LSB +: VXRM_W];
          end
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flags_q <= '0;
      rm_q    <= '0;
      vxsat_q <= 1'b0;
      vxrm_q  <= '0;
    end else begin
      flags_q <= flags_d;
      rm_q    <= rm_d;
      vxsat_q <= vxsat_d;
      vxrm_q  <= vxrm_d;
    end
  end

  // R6: without the vector extension a write keeps vector fields as they were
  p_vec_keep_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !vec_present) |=> ($stable(vxsat_q) && $stable(vxrm_q)));
endmodule

// File: rtl/fpcsr_unit.sv
module fpcsr_unit
  import fpcsr_pkg::*;
#(
  parameter int XLEN   = 32,
  parameter int ADDR_W = 12,
  parameter int FLAG_W = 5,
  parameter int RM_W   = 3,
  parameter int VXRM_W = 2,
  parameter logic [ADDR_W-1:0] ADDR_FLAGS = 12'h001,
  parameter logic [ADDR_W-1:0] ADDR_RMODE = 12'h002,
  parameter logic [ADDR_W-1:0] ADDR_FULL  = 12'h003
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic              req_we,
  input  logic [XLEN-1:0]   req_wdata,
  input  logic              fp_enable,
  input  logic              vec_present,
  input  logic              dbg_access,
  output logic [XLEN-1:0]   rsp_rdata,
  output logic              rsp_illegal,
  output logic              fs_dirty
);
  localparam int RM_LSB    = FLAG_W;
  localparam int VXSAT_POS = FLAG_W + RM_W;
  localparam int VXRM_LSB  = VXSAT_POS + 1;
  localparam int FULL_W    = VXRM_LSB + VXRM_W;

  view_e             view;
  logic              hit;
  logic              illegal;
  logic              wr_ok;
  logic [FLAG_W-1:0] flags_q;
  logic [RM_W-1:0]   rm_q;
  logic              vxsat_q;
  logic [VXRM_W-1:0] vxrm_q;
  logic              unused_hi;

  assign unused_hi = ^req_wdata[XLEN-1:FULL_W];

  fpcsr_decode #(
    .ADDR_W(ADDR_W), .ADDR_FLAGS(ADDR_FLAGS),
    .ADDR_RMODE(ADDR_RMODE), .ADDR_FULL(ADDR_FULL)
  ) u_decode (
    .req_valid(req_valid), .req_addr(req_addr), .view(view)
  );

  fpcsr_guard u_guard (
    .view(view), .fp_enable(fp_enable), .vec_present(vec_present),
    .dbg_access(dbg_access), .hit(hit), .illegal(illegal)
  );

  assign wr_ok = hit && req_we && !illegal;

  fpcsr_state #(
    .FLAG_W(FLAG_W), .RM_W(RM_W), .VXRM_W(VXRM_W)
  ) u_state (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_ok), .view(view),
    .vec_present(vec_present), .wdata(req_wdata[FULL_W-1:0]),
    .flags_q(flags_q), .rm_q(rm_q), .vxsat_q(vxsat_q), .vxrm_q(vxrm_q)
  );

  always_comb begin
    rsp_rdata = '0;
    if (!illegal) begin
      unique case (view)
        VIEW_FLAGS: rsp_rdata[FLAG_W-1:0] = flags_q;
        VIEW_RMODE: rsp_rdata[RM_W-1:0]   = rm_q;
        VIEW_FULL: begin
          rsp_rdata[FLAG_W-1:0]        = flags_q;
          rsp_rdata[RM_LSB +: RM_W]    = rm_q;
          if (vec_present) begin
            rsp_rdata[VXSAT_POS]         = vxsat_q;
            rsp_rdata[VXRM_LSB +: VXRM_W] = vxrm_q;
          end
        end
        default: ;
      endcase
    end
  end

  assign rsp_illegal = illegal;
  assign fs_dirty    = wr_ok;

  // R7: refused access leaves state alone and raises no dirty pulse
  p_illegal_quiet_r7: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_illegal |-> (!fs_dirty && rsp_rdata == '0));
  p_illegal_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_illegal |=> ($stable(flags_q) && $stable(rm_q) && $stable(vxsat_q) && $stable(vxrm_q)));
  // R10: dirty pulse only for a valid write request
  p_dirty_write_r10: assert property (@(posedge clk) disable iff (!rst_n)
    fs_dirty |-> (req_valid && req_we));
  // R2: flags view write stores the low field
  p_flags_store_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (fs_dirty && view == VIEW_FLAGS) |=> (flags_q == $past(req_wdata[FLAG_W-1:0])));
  // R6: vector bits read zero without the extension
  p_vec_zero_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !vec_present |-> (rsp_rdata[VXRM_LSB+VXRM_W-1:VXSAT_POS] == '0));
  // R12: foreign register numbers get no answer
  p_foreign_r12: assert property (@(posedge clk) disable iff (!rst_n)
    !hit |-> (!rsp_illegal && !fs_dirty && rsp_rdata == '0));
endmodule

// File: tb/fpcsr_unit_tb.sv
module fpcsr_unit_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic [11:0] req_addr = '0;
  logic        req_we = 1'b0;
  logic [31:0] req_wdata = '0;
  logic        fp_enable = 1'b1;
  logic        vec_present = 1'b0;
  logic        dbg_access = 1'b0;
  logic [31:0] rsp_rdata;
  logic        rsp_illegal;
  logic        fs_dirty;

  int n_checks = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  fpcsr_unit u_dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_addr(req_addr),
    .req_we(req_we), .req_wdata(req_wdata), .fp_enable(fp_enable),
    .vec_present(vec_present), .dbg_access(dbg_access),
    .rsp_rdata(rsp_rdata), .rsp_illegal(rsp_illegal), .fs_dirty(fs_dirty)
  );

  typedef struct packed {
    logic [11:0] addr;
    logic        we;
    logic [31:0] wdata;
    logic        fpen;
    logic        vec;
    logic        dbg;
    logic [31:0] exp_rd;
    logic        exp_ill;
    logic        exp_dirty;
    logic [3:0]  rq;
  } step_t;

  localparam int NSTEP = 28;
  localparam step_t TBL [NSTEP] = '{
    '{12'h003, 1'b0, 32'h0,         1'b1, 1'b0, 1'b0, 32'h0,   1'b0, 1'b0, 4'd1},  // R1
    '{12'h001, 1'b1, 32'hFFFF_FFFF, 1'b1, 1'b0, 1'b0, 32'h0,   1'b0, 1'b1, 4'd2},  // R2
    '{12'h001, 1'b0, 32'h0,         1'b1, 1'b0, 1'b0, 32'h1F,  1'b0, 1'b0, 4'd2},  // R2
    '{12'h003, 1'b0, 32'h0,         1'b1, 1'b0, 1'b0, 32'h1F,  1'b0, 1'b0, 4'd11}, // R11
    '{12'h002, 1'b1, 32'hFFFF_FFFD, 1'b1, 1'b0, 1'b0, 32'h0,   1'b0, 1'b1, 4'd3},  // R3
    '{12'h002, 1'b0, 32'h0,         1'b1, 1'b0, 1'b0, 32'h5,   1'b0, 1'b0, 4'd3},  // R3
    '{12'h003, 1'b0, 32'h0,         1'b1, 1'b0, 1'b0, 32'hBF,  1'b0, 1'b0, 4'd4},  // R4
    '{12'h003, 1'b1, 32'h0000_0746, 1'b1, 1'b0, 1'b0, 32'hBF,  1'b0, 1'b1, 4'd4},  // R4
    '{12'h003, 1'b0, 32'h0,         1'b1, 1'b0, 1'b0, 32'h46,  1'b0, 1'b0, 4'd6},  // R6
    '{12'h003, 1'b0, 32'h0,         1'b1, 1'b1, 1'b0, 32'h46,  1'b0, 1'b0, 4'd6},  // R6
    '{12'h003, 1'b1, 32'hFFFF_F6A9, 1'b1, 1'b1, 1'b0, 32'h46,  1'b0, 1'b1, 4'd5},  // R5
    '{12'h003, 1'b0, 32'h0,         1'b1, 1'b1, 1'b0, 32'h6A9, 1'b0, 1'b0, 4'd5},  // R5
    '{12'h003, 1'b0, 32'h0,         1'b1, 1'b0, 1'b0, 32'hA9,  1'b0, 1'b0, 4'd6},  // R6
    '{12'h001, 1'b0, 32'h0,         1'b1, 1'b1, 1'b0, 32'h9,   1'b0, 1'b0, 4'd11}, // R11
    '{12'h002, 1'b0, 32'h0,         1'b1, 1'b1, 1'b0, 32'h5,   1'b0, 1'b0, 4'd11}, // R11
    '{12'h001, 1'b1, 32'h0,         1'b0, 1'b0, 1'b0, 32'h0,   1'b1, 1'b0, 4'd7},  // R7
    '{12'h002, 1'b0, 32'h0,         1'b0, 1'b0, 1'b0, 32'h0,   1'b1, 1'b0, 4'd7},  // R7
    '{12'h003, 1'b1, 32'h0,         1'b0, 1'b0, 1'b0, 32'h0,   1'b1, 1'b0, 4'd7},  // R7
    '{12'h003, 1'b0, 32'h0,         1'b1, 1'b1, 1'b0, 32'h6A9, 1'b0, 1'b0, 4'd7},  // R7
    '{12'h002, 1'b1, 32'h2,         1'b0, 1'b0, 1'b1, 32'h5,   1'b0, 1'b1, 4'd8},  // R8
    '{12'h003, 1'b0, 32'h0,         1'b0, 1'b1, 1'b1, 32'h649, 1'b0, 1'b0, 4'd8},  // R8
    '{12'h003, 1'b0, 32'h0,         1'b0, 1'b1, 1'b0, 32'h649, 1'b0, 1'b0, 4'd9},  // R9
    '{12'h001, 1'b1, 32'h1F,        1'b0, 1'b1, 1'b0, 32'h0,   1'b1, 1'b0, 4'd9},  // R9
    '{12'h003, 1'b1, 32'h100,       1'b0, 1'b1, 1'b0, 32'h649, 1'b0, 1'b1, 4'd9},  // R9
    '{12'h003, 1'b0, 32'h0,         1'b1, 1'b1, 1'b0, 32'h100, 1'b0, 1'b0, 4'd9},  // R9
    '{12'h300, 1'b1, 32'hFFFF_FFFF, 1'b0, 1'b1, 1'b0, 32'h0,   1'b0, 1'b0, 4'd12}, // R12
    '{12'h003, 1'b0, 32'h0,         1'b1, 1'b1, 1'b0, 32'h100, 1'b0, 1'b0, 4'd12}, // R12
    '{12'h001, 1'b1, 32'h3,         1'b1, 1'b1, 1'b0, 32'h0,   1'b0, 1'b1, 4'd10}  // R10
  };

  task automatic check(input bit ok, input int rq, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL R%0d %s: actual %0h expected %0h", rq, what, act, exp);
    end
  endtask

  task automatic apply(input logic [11:0] a, input logic w, input logic [31:0] d,
                       input logic fe, input logic vp, input logic db);
    @(negedge clk);
    req_valid = 1'b1; req_addr = a; req_we = w; req_wdata = d;
    fp_enable = fe; vec_present = vp; dbg_access = db;
    #5;
  endtask

  initial begin
    #200000000;
    n_fail++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1: reset state seen through the combined view with vector fields on
    apply(12'h003, 1'b0, 32'h0, 1'b1, 1'b1, 1'b0);
    check(rsp_rdata == 32'h0, 1, "reset value", rsp_rdata, 32'h0);

    for (int i = 0; i < NSTEP; i++) begin
      apply(TBL[i].addr, TBL[i].we, TBL[i].wdata, TBL[i].fpen, TBL[i].vec, TBL[i].dbg);
      check(rsp_rdata == TBL[i].exp_rd, int'(TBL[i].rq), "rdata", rsp_rdata, TBL[i].exp_rd);
      check(rsp_illegal == TBL[i].exp_ill, int'(TBL[i].rq), "illegal",
            {31'b0, rsp_illegal}, {31'b0, TBL[i].exp_ill});
      check(fs_dirty == TBL[i].exp_dirty, int'(TBL[i].rq), "dirty",
            {31'b0, fs_dirty}, {31'b0, TBL[i].exp_dirty});
    end

    // R11: last table write of 0x03 to flags, seen through the combined view
    apply(12'h003, 1'b0, 32'h0, 1'b1, 1'b1, 1'b0);
    check(rsp_rdata == 32'h103, 11, "cross view", rsp_rdata, 32'h103);

    // R10: write flag without valid raises nothing and changes nothing
    @(negedge clk);
    req_valid = 1'b0; req_addr = 12'h001; req_we = 1'b1; req_wdata = 32'h1F;
    #5;
    check(fs_dirty == 1'b0, 10, "idle dirty", {31'b0, fs_dirty}, 32'h0);
    apply(12'h001, 1'b0, 32'h0, 1'b1, 1'b1, 1'b0);
    check(rsp_rdata == 32'h3, 10, "idle no write", rsp_rdata, 32'h3);
    check(fs_dirty == 1'b0, 10, "read dirty", {31'b0, fs_dirty}, 32'h0);

    // R1: reset again from a nonzero state
    @(negedge clk);
    req_valid = 1'b0;
    rst_n = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    apply(12'h003, 1'b0, 32'h0, 1'b1, 1'b1, 1'b0);
    check(rsp_rdata == 32'h0, 1, "reset clears", rsp_rdata, 32'h0);

    @(negedge clk);
    req_valid = 1'b0;
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
    $finish;
  end
endmodule